// File: doc/BRIEF.md
# Multithreaded Register Frame Switcher

This block keeps four hardware thread contexts resident inside a processor core. Each context owns one frame of the register file, a saved program counter, a thread tag and a blocked flag. The active context is named by a two-bit frame pointer. A context switch only moves that pointer and never copies registers, so it completes in a single clock.

Switches are started by events that carry a cause code. In block mode, only cache misses and synchronization faults cause a switch. In fine mode, every issued memory request also causes one. The next context is chosen round-robin, starting from the frame after the active one. A context that left because of a miss or a fault is held out until its completion arrives. When no context can run, the block idles and keeps its frame pointer. A core can also ask for a thread by its tag. If the tag is resident, the block switches straight to that frame. If it is not, the block raises a one-cycle trap so that software can unload one frame and load the wanted thread into it through the load port.

States: `ST_RUN` (active context executing), `ST_IDLE` (no eligible context) and `ST_TRAP` (one-cycle trap for a missing thread). Transitions: RUN→RUN (switch to an eligible frame, switch to a resident wanted thread, or no switch), RUN→IDLE (switch event with nothing eligible), RUN→TRAP (wanted thread not resident), IDLE→RUN (some context became eligible), IDLE→IDLE (none eligible), TRAP→RUN (always, after one cycle).

Top module: `ctx_frame_switch`

## Requirements
- R1: After reset the active context is 0 and its PC output is 0. `idle_o` and `trap_o` are low, frame f carries thread tag f, no context is blocked, and every register reads 0.
- R2: Register accesses are addressed as {frame pointer, register index}. A write to an index in one frame is read back from that frame and is not visible at the same index of another frame.
- R3: A register write issued in the same cycle as a switch lands in the frame that was active in that cycle.
- R4: Cause codes are 0 = none, 1 = cache miss, 2 = synchronization fault, 3 = memory request issued. In block mode (`fine_mode_i` = 0), codes 1 and 2 cause a switch. Codes 0 and 3 are ignored, and the active context stays the same.
- R5: In fine mode (`fine_mode_i` = 1), every nonzero cause code switches, including code 3.
- R6: A switch takes one clock. `cur_pc_i` is saved as the resume PC of the outgoing context. From the next cycle, `act_pc_o` shows the saved PC of the incoming context.
- R7: An event switch picks the first eligible context in the order fp+1, fp+2, fp+3, fp (modulo 4). A context is eligible when its `ready_mask_i` bit is 1 and it is not blocked.
- R8: A switch with cause 1 or 2 blocks the outgoing context. A switch with cause 3 does not. `done_valid_i` with `done_ctx_i` unblocks that context from the next cycle. A block and an unblock of the same context in the same cycle leave it blocked.
- R9: If a switch event finds no eligible context, `idle_o` rises and the frame pointer is held. In idle, events and wanted-thread requests are ignored. Once a context becomes eligible, the block switches to the first eligible one in round-robin order from fp+1, and `idle_o` falls.
- R10: `want_valid_i` in RUN takes priority over an event. If `want_tid_i` matches a frame's tag (the lowest-numbered frame wins), the block switches to that frame in one clock and saves `cur_pc_i` for the outgoing context.
- R11: If the wanted tag matches no frame, `trap_o` is high for exactly one cycle with `trap_tid_o` equal to that tag, and the frame pointer does not change. Events during the trap cycle are ignored.
- R12: `ld_valid_i` writes the tag and saved PC of frame `ld_frame_i` and unblocks it. This takes priority over a PC save to the same frame in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fine_mode_i | input | 1 | 0 = block mode, 1 = fine mode |
| evt_valid_i | input | 1 | Switch event present |
| evt_cause_i | input | 2 | Event cause code |
| cur_pc_i | input | PC_W | Resume PC of the active context, saved on a switch |
| ready_mask_i | input | 2**FP_W | Per-context ready bits |
| done_valid_i | input | 1 | Completion of an outstanding miss or fault |
| done_ctx_i | input | FP_W | Context whose miss or fault completed |
| want_valid_i | input | 1 | Request to run a thread given by tag |
| want_tid_i | input | TID_W | Tag of the wanted thread |
| ld_valid_i | input | 1 | Software load of a frame descriptor |
| ld_frame_i | input | FP_W | Frame being loaded |
| ld_tid_i | input | TID_W | New tag for the loaded frame |
| ld_pc_i | input | PC_W | New saved PC for the loaded frame |
| rd_idx_i | input | IDX_W | Read index within the active frame |
| rd_data_o | output | DATA_W | Read data (combinational) |
| wr_en_i | input | 1 | Register write enable |
| wr_idx_i | input | IDX_W | Write index within the active frame |
| wr_data_i | input | DATA_W | Write data |
| act_ctx_o | output | FP_W | Active frame pointer |
| act_pc_o | output | PC_W | Saved PC of the active context |
| idle_o | output | 1 | No context eligible |
| trap_o | output | 1 | Wanted thread is not resident |
| trap_tid_o | output | TID_W | Tag that caused the trap |

## Verification
The embedded properties check, on every cycle, the behaviour that can be stated locally. A trap lasts one cycle and leaves the frame pointer unchanged. The pointer never moves out of the trap state and is held while idle persists. Cause code 3 in block mode leaves the active context alone. An unblock takes effect. A frame load lands. A register write reaches the frame addressed by the pointer of that cycle. The round-robin order with skipped contexts, the saving and restoring of PCs across several switches, the isolation of frames, and the effect of a write in the switch cycle can only be shown by the bench. It runs directed sequences and a long seeded random run against a reference model built from the requirements.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_IDLE = 2'd1,
        ST_TRAP = 2'd2
    } ctx_state_e;

    localparam logic [1:0] CAUSE_NONE   = 2'd0;
    localparam logic [1:0] CAUSE_MISS   = 2'd1;
    localparam logic [1:0] CAUSE_SYNC   = 2'd2;
    localparam logic [1:0] CAUSE_MEMREQ = 2'd3;

endpackage

// File: rtl/ctx_rr_pick.sv
module ctx_rr_pick #(
    parameter int IW = 2,
    parameter int N  = 1 << IW
) (
    input  logic [IW-1:0] base_i,
    input  logic [N-1:0]  req_i,
    output logic [IW-1:0] pick_o,
    output logic          found_o
);

    logic [IW-1:0] cand;

    // search base+1 .. base+N, the last candidate wraps back to base itself
    always_comb begin
        found_o = 1'b0;
        pick_o  = base_i;
        cand    = base_i;
        for (int k = 1; k <= N; k++) begin
            cand = base_i + IW'(k);
            if (!found_o && req_i[cand]) begin
                found_o = 1'b1;
                pick_o  = cand;
            end
        end
    end

endmodule

// File: rtl/ctx_regfile.sv
module ctx_regfile #(
    parameter int FP_W   = 2,
    parameter int IDX_W  = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FP_W-1:0]   fp_i,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int ADDR_W = FP_W + IDX_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr;

    assign waddr = {fp_i, wr_idx_i};
    assign raddr = {fp_i, rd_idx_i};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en_i) begin
            mem[waddr] <= wr_data_i;
        end
    end

    assign rd_data_o = mem[raddr];

    // R3
    wr_lands_in_cur_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> mem[$past(waddr)] == $past(wr_data_i));

endmodule

// File: rtl/ctx_table.sv
module ctx_table #(
    parameter int FP_W  = 2,
    parameter int TID_W = 3,
    parameter int PC_W  = 32,
    parameter int N     = 1 << FP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FP_W-1:0]  fp_i,
    input  logic             save_en_i,
    input  logic [PC_W-1:0]  save_pc_i,
    input  logic             blk_set_i,
    input  logic             done_v_i,
    input  logic [FP_W-1:0]  done_ctx_i,
    input  logic             ld_v_i,
    input  logic [FP_W-1:0]  ld_frame_i,
    input  logic [TID_W-1:0] ld_tid_i,
    input  logic [PC_W-1:0]  ld_pc_i,
    input  logic [TID_W-1:0] want_tid_i,
    output logic [N-1:0]     blk_o,
    output logic [PC_W-1:0]  act_pc_o,
    output logic             hit_o,
    output logic [FP_W-1:0]  hit_frame_o
);

    logic [N-1:0][PC_W-1:0]  pc_vec;
    logic [N-1:0][TID_W-1:0] tid_vec;

    for (genvar g = 0; g < N; g++) begin : g_ctx
        logic [PC_W-1:0]  pc_q;
        logic [TID_W-1:0] tid_q;
        logic             blk_q;
        logic             sel_fp;
        logic             sel_ld;

        assign sel_fp = (fp_i == FP_W'(g));
        assign sel_ld = ld_v_i && (ld_frame_i == FP_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pc_q  <= '0;
                tid_q <= TID_W'(g);
                blk_q <= 1'b0;
            end else begin
                if (save_en_i && sel_fp) begin
                    pc_q <= save_pc_i;
                end
                if (done_v_i && done_ctx_i == FP_W'(g)) begin
                    blk_q <= 1'b0;
                end
                if (blk_set_i && sel_fp) begin
                    blk_q <= 1'b1;
                end
                if (sel_ld) begin
                    pc_q  <= ld_pc_i;
                    tid_q <= ld_tid_i;
                    blk_q <= 1'b0;
                end
            end
        end

        assign pc_vec[g]  = pc_q;
        assign tid_vec[g] = tid_q;
        assign blk_o[g]   = blk_q;
    end

    assign act_pc_o = pc_vec[fp_i];

    // lowest matching frame wins: scan downward so the last hit is the lowest
    always_comb begin
        hit_o       = 1'b0;
        hit_frame_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (tid_vec[i] == want_tid_i) begin
                hit_o       = 1'b1;
                hit_frame_o = FP_W'(i);
            end
        end
    end

    // R8
    unblock_takes_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_v_i && !(blk_set_i && fp_i == done_ctx_i)) |=> !blk_o[$past(done_ctx_i)]);

    // R12
    load_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_v_i |=> (tid_vec[$past(ld_frame_i)] == $past(ld_tid_i)) &&
                   (pc_vec[$past(ld_frame_i)] == $past(ld_pc_i)) &&
                   !blk_o[$past(ld_frame_i)]);

endmodule

// File: rtl/ctx_frame_switch.sv
module ctx_frame_switch
    import ctx_pkg::*;
#(
    parameter int FP_W   = 2,
    parameter int IDX_W  = 3,
    parameter int DATA_W = 32,
    parameter int PC_W   = 32,
    parameter int TID_W  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fine_mode_i,
    input  logic                  evt_valid_i,
    input  logic [1:0]            evt_cause_i,
    input  logic [PC_W-1:0]       cur_pc_i,
    input  logic [(1<<FP_W)-1:0]  ready_mask_i,
    input  logic                  done_valid_i,
    input  logic [FP_W-1:0]       done_ctx_i,
    input  logic                  want_valid_i,
    input  logic [TID_W-1:0]      want_tid_i,
    input  logic                  ld_valid_i,
    input  logic [FP_W-1:0]       ld_frame_i,
    input  logic [TID_W-1:0]      ld_tid_i,
    input  logic [PC_W-1:0]       ld_pc_i,
    input  logic [IDX_W-1:0]      rd_idx_i,
    output logic [DATA_W-1:0]     rd_data_o,
    input  logic                  wr_en_i,
    input  logic [IDX_W-1:0]      wr_idx_i,
    input  logic [DATA_W-1:0]     wr_data_i,
    output logic [FP_W-1:0]       act_ctx_o,
    output logic [PC_W-1:0]       act_pc_o,
    output logic                  idle_o,
    output logic                  trap_o,
    output logic [TID_W-1:0]      trap_tid_o
);

    localparam int NUM_CTX = 1 << FP_W;

    ctx_state_e         st_q, st_d;
    logic [FP_W-1:0]    fp_q, fp_d;
    logic [TID_W-1:0]   trap_tid_q, trap_tid_d;

    logic               evt_takes;
    logic               evt_blocks;
    logic               in_run;
    logic               sw_evt;
    logic               want_hit_go;
    logic               save_en;
    logic               blk_set;
    logic [NUM_CTX-1:0] blk;
    logic [NUM_CTX-1:0] self_mask;
    logic [NUM_CTX-1:0] pick_req;
    logic [FP_W-1:0]    pick;
    logic               pick_found;
    logic               hit;
    logic [FP_W-1:0]    hit_frame;

    // event qualification by mode and cause
    assign evt_takes  = evt_valid_i && (evt_cause_i != CAUSE_NONE) &&
                        (fine_mode_i || evt_cause_i != CAUSE_MEMREQ);
    assign evt_blocks = evt_takes && (evt_cause_i != CAUSE_MEMREQ);

    assign in_run      = (st_q == ST_RUN);
    assign want_hit_go = in_run && want_valid_i && hit;
    assign sw_evt      = in_run && !want_valid_i && evt_takes;
    assign blk_set     = sw_evt && evt_blocks;
    assign save_en     = want_hit_go || sw_evt;

    assign self_mask = blk_set ? (NUM_CTX'(1) << fp_q) : '0;
    assign pick_req  = ready_mask_i & ~blk & ~self_mask;

    ctx_rr_pick #(
        .IW (FP_W)
    ) u_pick (
        .base_i  (fp_q),
        .req_i   (pick_req),
        .pick_o  (pick),
        .found_o (pick_found)
    );

    ctx_table #(
        .FP_W  (FP_W),
        .TID_W (TID_W),
        .PC_W  (PC_W)
    ) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .fp_i        (fp_q),
        .save_en_i   (save_en),
        .save_pc_i   (cur_pc_i),
        .blk_set_i   (blk_set),
        .done_v_i    (done_valid_i),
        .done_ctx_i  (done_ctx_i),
        .ld_v_i      (ld_valid_i),
        .ld_frame_i  (ld_frame_i),
        .ld_tid_i    (ld_tid_i),
        .ld_pc_i     (ld_pc_i),
        .want_tid_i  (want_tid_i),
        .blk_o       (blk),
        .act_pc_o    (act_pc_o),
        .hit_o       (hit),
        .hit_frame_o (hit_frame)
    );

    ctx_regfile #(
        .FP_W   (FP_W),
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W)
    ) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .fp_i      (fp_q),
        .wr_en_i   (wr_en_i),
        .wr_idx_i  (wr_idx_i),
        .wr_data_i (wr_data_i),
        .rd_idx_i  (rd_idx_i),
        .rd_data_o (rd_data_o)
    );

    // next-state logic
    always_comb begin
        st_d       = st_q;
        fp_d       = fp_q;
        trap_tid_d = trap_tid_q;
        unique case (st_q)
            ST_RUN: begin
                if (want_valid_i) begin
                    if (hit) begin
                        fp_d = hit_frame;
                    end else begin
                        st_d       = ST_TRAP;
                        trap_tid_d = want_tid_i;
                    end
                end else if (evt_takes) begin
                    if (pick_found) begin
                        fp_d = pick;
                    end else begin
                        st_d = ST_IDLE;
                    end
                end
            end
            ST_IDLE: begin
                if (pick_found) begin
                    fp_d = pick;
                    st_d = ST_RUN;
                end
            end
            ST_TRAP: begin
                st_d = ST_RUN;
            end
            default: begin
                st_d = ST_RUN;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_RUN;
            fp_q       <= '0;
            trap_tid_q <= '0;
        end else begin
            st_q       <= st_d;
            fp_q       <= fp_d;
            trap_tid_q <= trap_tid_d;
        end
    end

    // outputs
    always_comb begin
        act_ctx_o  = fp_q;
        idle_o     = (st_q == ST_IDLE);
        trap_o     = (st_q == ST_TRAP);
        trap_tid_o = trap_tid_q;
    end

    // R11
    trap_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |=> !trap_o);

    // R11
    trap_keeps_fp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trap_o) |-> $stable(act_ctx_o));

    // R6
    fp_moves_only_on_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |=> $stable(act_ctx_o));

    // R9
    idle_holds_fp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |=> (!idle_o || $stable(act_ctx_o)));

    // R4
    block_mode_memreq_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && !fine_mode_i && evt_valid_i && evt_cause_i == CAUSE_MEMREQ && !want_valid_i)
        |=> (!idle_o && !trap_o && $stable(act_ctx_o)));

endmodule

// File: tb/tb_ctx_frame_switch.sv
`timescale 1ns/1ps
module tb_ctx_frame_switch;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fine_mode_i, evt_valid_i, done_valid_i, want_valid_i, ld_valid_i, wr_en_i;
    logic [1:0]  evt_cause_i, done_ctx_i, ld_frame_i;
    logic [31:0] cur_pc_i, ld_pc_i, wr_data_i, rd_data_o, act_pc_o;
    logic [3:0]  ready_mask_i;
    logic [2:0]  want_tid_i, ld_tid_i, rd_idx_i, wr_idx_i, trap_tid_o;
    logic [1:0]  act_ctx_o;
    logic        idle_o, trap_o;

    always #5 clk = ~clk;

    ctx_frame_switch dut (
        .clk(clk), .rst_n(rst_n), .fine_mode_i(fine_mode_i),
        .evt_valid_i(evt_valid_i), .evt_cause_i(evt_cause_i), .cur_pc_i(cur_pc_i),
        .ready_mask_i(ready_mask_i), .done_valid_i(done_valid_i), .done_ctx_i(done_ctx_i),
        .want_valid_i(want_valid_i), .want_tid_i(want_tid_i),
        .ld_valid_i(ld_valid_i), .ld_frame_i(ld_frame_i), .ld_tid_i(ld_tid_i), .ld_pc_i(ld_pc_i),
        .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o),
        .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
        .act_ctx_o(act_ctx_o), .act_pc_o(act_pc_o), .idle_o(idle_o),
        .trap_o(trap_o), .trap_tid_o(trap_tid_o)
    );

    int checks = 0;
    int fails  = 0;

    // reference model (0 run, 1 idle, 2 trap)
    int          m_st;
    int          m_fp;
    logic [31:0] m_pc [4];
    logic [2:0]  m_tid [4];
    logic [3:0]  m_blk;
    logic [2:0]  m_trapid;
    logic [31:0] m_rf [32];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] rr(input int base, input logic [3:0] req);
        for (int k = 1; k <= 4; k++) begin
            int c = (base + k) % 4;
            if (req[c]) return {1'b1, 2'(c)};
        end
        return 3'b000;
    endfunction

    task automatic model_reset();
        m_st = 0; m_fp = 0; m_blk = '0; m_trapid = '0;
        for (int i = 0; i < 4; i++) begin m_pc[i] = '0; m_tid[i] = 3'(i); end
        for (int i = 0; i < 32; i++) m_rf[i] = '0;
    endtask

    task automatic model_step();
        logic [31:0] npc [4];
        logic [3:0]  nblk;
        int          nfp, nst, setc, hitf;
        bit          setb, takes;
        logic [2:0]  r;
        for (int i = 0; i < 4; i++) npc[i] = m_pc[i];
        nblk = m_blk; nfp = m_fp; nst = m_st; setb = 0; setc = 0; hitf = -1;
        if (wr_en_i) m_rf[{2'(m_fp), wr_idx_i}] = wr_data_i;
        takes = evt_valid_i && evt_cause_i != 2'd0 && (fine_mode_i || evt_cause_i != 2'd3);
        case (m_st)
            0: begin
                if (want_valid_i) begin
                    for (int i = 3; i >= 0; i--) if (m_tid[i] == want_tid_i) hitf = i;
                    if (hitf >= 0) begin npc[m_fp] = cur_pc_i; nfp = hitf; end
                    else begin nst = 2; m_trapid = want_tid_i; end
                end else if (takes) begin
                    npc[m_fp] = cur_pc_i;
                    if (evt_cause_i != 2'd3) begin setb = 1; setc = m_fp; end
                    r = rr(m_fp, ready_mask_i & ~m_blk & ~(setb ? 4'(1 << m_fp) : 4'd0));
                    if (r[2]) nfp = r[1:0]; else nst = 1;
                end
            end
            1: begin
                r = rr(m_fp, ready_mask_i & ~m_blk);
                if (r[2]) begin nfp = r[1:0]; nst = 0; end
            end
            default: nst = 0;
        endcase
        if (done_valid_i) nblk[done_ctx_i] = 1'b0;
        if (setb) nblk[setc] = 1'b1;
        if (ld_valid_i) begin
            npc[ld_frame_i] = ld_pc_i; m_tid[ld_frame_i] = ld_tid_i; nblk[ld_frame_i] = 1'b0;
        end
        for (int i = 0; i < 4; i++) m_pc[i] = npc[i];
        m_blk = nblk; m_fp = nfp; m_st = nst;
    endtask

    task automatic compare_model();
        chk("R7/R10 act_ctx vs model", 32'(act_ctx_o), 32'(m_fp));
        chk("R6/R12 act_pc vs model", act_pc_o, m_pc[m_fp]);
        chk("R9 idle vs model", 32'(idle_o), 32'(m_st == 1));
        chk("R11 trap vs model", 32'(trap_o), 32'(m_st == 2));
        if (m_st == 2) chk("R11 trap_tid vs model", 32'(trap_tid_o), 32'(m_trapid));
        chk("R2/R3 rd_data vs model", rd_data_o, m_rf[{2'(m_fp), rd_idx_i}]);
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_model();
    endtask

    task automatic quiet();
        evt_valid_i = 0; evt_cause_i = 0; done_valid_i = 0; want_valid_i = 0;
        ld_valid_i = 0; wr_en_i = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int seed = 32'h5eed_1234;
        void'($urandom(seed));
        rst_n = 0; fine_mode_i = 0; quiet(); cur_pc_i = 0; ready_mask_i = 4'hF;
        done_ctx_i = 0; want_tid_i = 0; ld_frame_i = 0; ld_tid_i = 0; ld_pc_i = 0;
        rd_idx_i = 0; wr_idx_i = 0; wr_data_i = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 act_ctx", 32'(act_ctx_o), 0);
        chk("R1 act_pc", act_pc_o, 0);
        chk("R1 idle", 32'(idle_o), 0);
        chk("R1 trap", 32'(trap_o), 0);
        chk("R1 reg zero", rd_data_o, 0);

        // R2 write frame 0 index 5
        wr_en_i = 1; wr_idx_i = 5; wr_data_i = 32'hAAAA_0005; rd_idx_i = 5;
        tick(); quiet();
        chk("R2 readback frame0", rd_data_o, 32'hAAAA_0005);

        // R4 memreq ignored in block mode
        evt_valid_i = 1; evt_cause_i = 2'd3; cur_pc_i = 32'h0000_0999;
        tick(); quiet();
        chk("R4 memreq ignored", 32'(act_ctx_o), 0);

        // R4/R6 miss switches; R3 write in switch cycle goes to frame 0
        evt_valid_i = 1; evt_cause_i = 2'd1; cur_pc_i = 32'h0000_0100;
        wr_en_i = 1; wr_idx_i = 5; wr_data_i = 32'hBBBB_0005;
        tick(); quiet();
        chk("R4 miss switch", 32'(act_ctx_o), 1);
        chk("R6 incoming pc", act_pc_o, 0);
        chk("R2 frame isolation", rd_data_o, 0);

        // R7 skip not-ready and blocked
        ready_mask_i = 4'b1001; evt_valid_i = 1; evt_cause_i = 2'd1; cur_pc_i = 32'h0000_0111;
        tick(); quiet();
        chk("R7 skip to ctx3", 32'(act_ctx_o), 3);

        // R9 nothing eligible
        evt_valid_i = 1; evt_cause_i = 2'd2; cur_pc_i = 32'h0000_0333;
        tick(); quiet();
        chk("R9 idle raised", 32'(idle_o), 1);
        chk("R9 fp held", 32'(act_ctx_o), 3);

        // R8 completion of ctx0
        done_valid_i = 1; done_ctx_i = 0;
        tick(); quiet();
        chk("R9 still idle", 32'(idle_o), 1);
        tick();
        chk("R8 unblocked ctx0 runs", 32'(act_ctx_o), 0);
        chk("R6 restored pc", act_pc_o, 32'h0000_0100);
        chk("R9 idle cleared", 32'(idle_o), 0);
        chk("R3 write went to old frame", rd_data_o, 32'hBBBB_0005);

        // R5 fine mode memreq switches, R8 memreq does not block
        fine_mode_i = 1; ready_mask_i = 4'hF;
        evt_valid_i = 1; evt_cause_i = 2'd3; cur_pc_i = 32'h0000_0200;
        tick(); quiet();
        chk("R5 fine memreq switch", 32'(act_ctx_o), 2);

        // R12 load frame1, R10 want resident tag
        ld_valid_i = 1; ld_frame_i = 1; ld_tid_i = 3'd6; ld_pc_i = 32'h0000_0340;
        tick(); quiet();
        want_valid_i = 1; want_tid_i = 3'd6; cur_pc_i = 32'h0000_0220;
        tick(); quiet();
        chk("R10 want switch", 32'(act_ctx_o), 1);
        chk("R12 loaded pc", act_pc_o, 32'h0000_0340);

        // R11 non-resident tag
        want_valid_i = 1; want_tid_i = 3'd7;
        tick(); quiet();
        chk("R11 trap high", 32'(trap_o), 1);
        chk("R11 trap tid", 32'(trap_tid_o), 7);
        chk("R11 fp kept", 32'(act_ctx_o), 1);
        evt_valid_i = 1; evt_cause_i = 2'd1; cur_pc_i = 32'h0000_0777;
        tick(); quiet();
        chk("R11 trap one cycle", 32'(trap_o), 0);
        chk("R11 event ignored in trap", 32'(act_ctx_o), 1);

        // random phase against model
        for (int n = 0; n < 4000; n++) begin
            fine_mode_i  = ($urandom % 4) == 0 ? ~fine_mode_i : fine_mode_i;
            evt_valid_i  = ($urandom % 3) == 0;
            evt_cause_i  = 2'($urandom);
            cur_pc_i     = $urandom;
            ready_mask_i = 4'($urandom) | 4'($urandom);
            done_valid_i = ($urandom % 3) == 0;
            done_ctx_i   = 2'($urandom);
            want_valid_i = ($urandom % 16) == 0;
            want_tid_i   = 3'($urandom);
            ld_valid_i   = ($urandom % 20) == 0;
            ld_frame_i   = 2'($urandom);
            ld_tid_i     = 3'($urandom);
            ld_pc_i      = $urandom;
            wr_en_i      = ($urandom % 2) == 0;
            wr_idx_i     = 3'($urandom);
            wr_data_i    = $urandom;
            rd_idx_i     = 3'($urandom);
            tick();
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule